// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a hardware watchdog. After reset it does nothing: no counting and no reset output. Software turns it on by writing two bytes in a row to a single refresh register, first 0x1E and then 0xE1. From that point the watchdog counts machine cycles through a prescaler. Software must write the same two-byte sequence again before the count runs out. Each complete sequence puts the count back to zero.

Software cannot turn the watchdog off once it runs. Only a system reset does that. If the count runs out, the block raises a reset-out pulse of fixed length and then goes back to its idle, disarmed state. A second register holds a 3-bit timeout selector. Each step of the selector doubles the timeout.

The core counter is `CNT_W` bits wide (14 by default). The timeout is therefore 2^(CNT_W+sel) machine cycles.

Top module: `wdog_seq_top`

## Requirements
- R1: After reset, `rst_out_o` is low and stays low however many machine cycles pass, as long as no complete unlock sequence is written.
- R2: Two write cycles to address 0xA6 arm the watchdog: data 0x1E, then data 0xE1 on the very next write to that address. Arming takes effect at the clock edge that samples the 0xE1 write.
- R3: The timeout selector sits at address 0xA7, in data bits [2:0], and resets to 0. With `mc_en_i` held high, `rst_out_o` rises at the 2^(CNT_W+sel)-th rising clock edge after the edge that armed or refreshed the watchdog.
- R4: A complete sequence written while the watchdog runs clears the count and prescaler. The next expiry then falls 2^(CNT_W+sel) machine cycles after that refresh.
- R5: Once the watchdog is armed, writing other values to 0xA6 neither disarms it nor delays the expiry.
- R6: The reset-out pulse stays high for exactly 16 machine cycles. Afterwards the watchdog is disarmed and produces no further pulse until it is armed again.
- R7: Two kinds of write to 0xA6 break the sequence. One is a write of 0xE1 not directly preceded by 0x1E. The other is any value other than 0x1E written between the two bytes. Either write abandons the partial sequence, and it neither arms nor refreshes.
- R8: The counter and the pulse length advance only in cycles where `mc_en_i` is high. With `mc_en_i` high every other cycle, expiry takes 2·2^(CNT_W+sel) or one less clock cycle, and the pulse lasts 32 clock cycles.
- R9: Writes to addresses other than 0xA6 and 0xA7 do not break a sequence in progress.
- R10: Asserting `rst_ni` low drops `rst_out_o` at once and disarms the watchdog, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| mc_en_i | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rst_out_o | output | 1 | Reset-out pulse on expiry |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and that at most one register write arrives per cycle. They also assume that address and data are valid in every cycle where the write strobe is high, and that `rst_ni` is the only thing that clears the block from outside. The stimulus changes every input on the falling clock edge and holds each write for exactly one cycle. The machine-cycle enable is either held high or toggled every cycle. Reset is released on a falling edge, so no input changes near the sampling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  typedef enum logic [1:0] {
    WD_OFF  = 2'd0,
    WD_RUN  = 2'd1,
    WD_FIRE = 2'd2
  } wd_state_e;

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  KEY_ADDR = 8'hA6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              block_i,
  output logic              refresh_o
);
  import wdog_pkg::*;

  logic pending_q, pending_d;
  logic key_hit;

  always_comb begin
    key_hit   = wr_en_i && (wr_addr_i == ADDR_W'(KEY_ADDR)) && !block_i;
    pending_d = pending_q;
    refresh_o = 1'b0;
    if (block_i) begin
      pending_d = 1'b0;
    end else if (key_hit) begin
      refresh_o = pending_q && (wr_data_i == KEY_SECOND);
      pending_d = (wr_data_i == KEY_FIRST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= pending_d;
  end

  // R7: any non-first byte to the key address leaves no partial sequence
  assert_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(KEY_ADDR) && wr_data_i != KEY_FIRST) |=> !pending_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 14,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;
  logic [CNT_W-1:0] core_q, core_d;
  logic             step;

  always_comb begin
    for (int b = 0; b < PRE_W; b++) mask[b] = (b < int'(sel_i));
    step     = tick_i && ((pre_q & mask) == mask);
    expire_o = run_i && !clear_i && step && (&core_q);
    pre_d    = pre_q;
    core_d   = core_q;
    if (!run_i || clear_i) begin
      pre_d  = '0;
      core_d = '0;
    end else if (tick_i) begin
      pre_d = pre_q + 1'b1;
      if (step) core_d = core_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      core_q <= '0;
    end else begin
      pre_q  <= pre_d;
      core_q <= core_d;
    end
  end

  // R8: without a machine-cycle tick the count does not move
  assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !clear_i) |=> $stable(core_q));

  // R4: a refresh leaves count and prescaler at zero
  assert_refresh_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (core_q == '0 && pre_q == '0));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic active_o,
  output logic done_o
);
  localparam int PCW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic           active_q, active_d;
  logic [PCW-1:0] cnt_q, cnt_d;

  always_comb begin
    done_o   = active_q && tick_i && (cnt_q == PCW'(PULSE_LEN - 1));
    active_d = active_q;
    cnt_d    = cnt_q;
    if (start_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (done_o) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q && tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

  // R8: pulse length is counted only in machine cycles
  assert_pulse_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i) |=> active_q);

endmodule

// File: rtl/wdog_seq_top.sv
module wdog_seq_top #(
  parameter int         CNT_W     = 14,
  parameter int         SEL_W     = 3,
  parameter int         PULSE_LEN = 16,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] KEY_ADDR  = 8'hA6,
  parameter logic [7:0] SEL_ADDR  = 8'hA7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              rst_out_o
);
  import wdog_pkg::*;

  wd_state_e        state_q, state_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             refresh, expire, pulse_done, pulse_on, running;

  assign running = (state_q == WD_RUN);

  wdog_unlock #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .block_i   (pulse_on),
    .refresh_o (refresh)
  );

  wdog_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (running),
    .clear_i  (refresh),
    .tick_i   (mc_en_i),
    .sel_i    (sel_q),
    .expire_o (expire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (expire),
    .tick_i   (mc_en_i),
    .active_o (pulse_on),
    .done_o   (pulse_done)
  );

  always_comb begin
    sel_d = sel_q;
    if (wr_en_i && wr_addr_i == ADDR_W'(SEL_ADDR)) sel_d = wr_data_i[SEL_W-1:0];
    state_d = state_q;
    case (state_q)
      WD_OFF:  if (refresh)    state_d = WD_RUN;
      WD_RUN:  if (expire)     state_d = WD_FIRE;
      WD_FIRE: if (pulse_done) state_d = WD_OFF;
      default:                 state_d = WD_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_OFF;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

  assign rst_out_o = pulse_on;

  // R1: disarmed watchdog never drives reset-out
  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_OFF) |-> !rst_out_o);

  // R2: a completed sequence leaves the watchdog running
  assert_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> (state_q == WD_RUN));

  // R5: only expiry leaves the running state
  assert_no_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !expire) |=> running);

  // R6: firing state and reset-out pulse agree
  assert_fire_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_FIRE) |-> rst_out_o);

endmodule

// File: tb/wdog_seq_top_tb_top.sv
module wdog_seq_top_tb_top;

  localparam int CW = 8;
  localparam int N0 = 1 << CW;
  localparam logic [7:0] A_KEY = 8'hA6;
  localparam logic [7:0] A_SEL = 8'hA7;

  localparam logic [2:0] SEL_TBL [4] = '{3'd0, 3'd1, 3'd3, 3'd7};
  localparam int         EXP_TBL [4] = '{256, 512, 2048, 32768};

  logic       clk = 1'b0;
  logic       rst_n, mc_en, wr_en;
  logic [7:0] wr_addr, wr_data;
  logic       rst_out;
  int         checks = 0, errors = 0;
  bit         half_rate = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) mc_en <= half_rate ? ~mc_en : 1'b1;

  wdog_seq_top #(.CNT_W(CW)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mc_en_i   (mc_en),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rst_out_o (rst_out)
  );

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rst_out got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; half_rate = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm();
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'hE1);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_out === 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input string tag, input int n);
    int hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (rst_out !== 1'b0) hits++;
    end
    chk_int(tag, hits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    int t;
    mc_en = 1'b1;
    apply_reset();

    // R3/R2/R6: table of selector values and expected delays
    for (int i = 0; i < 4; i++) begin
      apply_reset();
      wr(A_SEL, {5'b0, SEL_TBL[i]});
      arm();
      wait_neg(EXP_TBL[i] - 1);
      chk_bit("R3 before expiry", rst_out, 1'b0);
      wait_neg(1);
      chk_bit("R3 R2 at expiry", rst_out, 1'b1);
      pulse_len(len);
      chk_int("R6 pulse length", len, 16);
    end

    // R1: reset state and idle behaviour
    apply_reset();
    chk_bit("R1 after reset", rst_out, 1'b0);
    quiet("R1 idle window", N0 + 20);

    // R7: lone second byte does not arm
    wr(A_KEY, 8'hE1);
    quiet("R7 lone second byte", N0 + 20);

    // R7: broken sequence while armed does not refresh
    arm();
    wait_neg(50);
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'h55);
    wr(A_KEY, 8'hE1);
    wait_neg(N0 - 1 - 53);
    chk_bit("R7 before original expiry", rst_out, 1'b0);
    wait_neg(1);
    chk_bit("R7 broken sequence no refresh", rst_out, 1'b1);
    pulse_len(len);
    chk_int("R6 pulse length after R7", len, 16);
    quiet("R6 disarmed after pulse", 2 * N0);

    // R9: unrelated write between the bytes keeps the sequence
    apply_reset();
    wr(A_KEY, 8'h1E);
    wr(8'h20, 8'h33);
    wr(A_KEY, 8'hE1);
    wait_neg(N0 - 1);
    chk_bit("R9 before expiry", rst_out, 1'b0);
    wait_neg(1);
    chk_bit("R9 armed through foreign write", rst_out, 1'b1);

    // R4: refresh restarts the count
    apply_reset();
    arm();
    wait_neg(100);
    arm();
    wait_neg(N0 - 1);
    chk_bit("R4 refresh postpones expiry", rst_out, 1'b0);
    wait_neg(1);
    chk_bit("R4 expiry after refresh", rst_out, 1'b1);

    // R5: other values cannot disarm
    apply_reset();
    arm();
    wr(A_KEY, 8'h00);
    wr(A_KEY, 8'hE1);
    wr(A_KEY, 8'h1E);
    wait_neg(N0 - 1 - 3);
    chk_bit("R5 before expiry", rst_out, 1'b0);
    wait_neg(1);
    chk_bit("R5 still expires", rst_out, 1'b1);

    // R10: async reset in the middle of a pulse
    wait_neg(3);
    rst_n = 1'b0;
    #1;
    chk_bit("R10 reset drops pulse", rst_out, 1'b0);
    wait_neg(2);
    rst_n = 1'b1;
    quiet("R10 disarmed by reset", N0 + 20);

    // R8: half-rate machine cycles
    apply_reset();
    half_rate = 1'b1;
    arm();
    t = 0;
    while (rst_out !== 1'b1 && t < 4 * N0) begin
      @(negedge clk);
      t++;
    end
    checks++;
    if (t != 2 * N0 && t != 2 * N0 - 1) begin
      errors++;
      $display("FAIL R8 half-rate expiry: got %0d expected %0d or %0d", t, 2 * N0 - 1, 2 * N0);
    end
    pulse_len(len);
    chk_int("R8 half-rate pulse length", len, 32);
    half_rate = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule